// File: doc/BRIEF.md
# Depth Cascade Token Link

This block lets several FIFO instances act as one deeper FIFO. Each instance owns a slice of storage. The instances are joined in a ring: each instance's expansion input is wired to the previous instance's expansion output. Two tokens travel around the ring. The instance holding the write token accepts writes, and the instance holding the read token accepts reads. When an instance writes its last storage location, it gives up the write token. When it reads its last location, it gives up the read token. In both cases the hand-off is a one-cycle low pulse on the expansion output, and the next instance in the ring takes the token from that pulse.

The instance keeps its own write and read pointers and a fill count. These produce the storage addresses and stop accepted strobes from overrunning the local slice. During reset, two pin levels are captured. A low expansion input puts the instance in standalone mode; in that mode it owns both directions permanently and the expansion output carries a more-than-half-full indication. A low first-load input marks the one ring member that starts with both tokens. Storage itself and the remaining status flags live outside this block.

Top module: `depth_chain_link`

## Requirements
- R1: The level of `expInN` during reset selects the mode. Low gives standalone mode; high gives cascade mode. The mode holds until the next reset.
- R2: After reset in cascade mode, an instance whose `firstLoadN` was low owns both tokens, and every other instance owns neither. On every instance, `wrAddr` and `rdAddr` start at 0.
- R3: In standalone mode, `ownsWr` and `ownsRd` stay high at all times and `expInN` has no effect.
- R4: `wrGo` is high only when `wrReq` is high, the instance owns the write token and the local fill count is below DEPTH. `rdGo` is high only when `rdReq` is high, the instance owns the read token and the fill count is above 0. Each accepted operation moves its address one step on the next clock, wrapping from DEPTH-1 to 0.
- R5: In cascade mode, an accepted write at address DEPTH-1 drives `expOutN` low for exactly the following cycle and clears `ownsWr` in that same cycle.
- R6: In cascade mode, an accepted read at address DEPTH-1 drives `expOutN` low for exactly the following cycle and clears `ownsRd` in that same cycle.
- R7: In cascade mode, each clock edge at which `expInN` is low counts as one arrival. After reset, arrivals alternate between granting the write token and granting the read token, beginning with write. The grant becomes visible after that edge.
- R8: In standalone mode, `expOutN` is low exactly when the registered fill count exceeds DEPTH/2.
- R9: In cascade mode, `expOutN` is high in every cycle other than those named in R5 and R6.
- R10: A strobe that is not accepted, for example because its token is absent, leaves its address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; mode and first-load levels are captured while it is low |
| wrReq | input | 1 | Local write strobe request |
| rdReq | input | 1 | Local read strobe request |
| expInN | input | 1 | Expansion input: token pulses from the previous ring member, or tied low for standalone mode |
| firstLoadN | input | 1 | Low on the single ring member that starts with both tokens |
| wrGo | output | 1 | Gated write strobe for the storage |
| rdGo | output | 1 | Gated read strobe for the storage |
| wrAddr | output | $clog2(DEPTH) | Local write address |
| rdAddr | output | $clog2(DEPTH) | Local read address |
| ownsWr | output | 1 | This instance holds the write token |
| ownsRd | output | 1 | This instance holds the read token |
| expOutN | output | 1 | Low pulse for each token hand-off in cascade mode; low when more than half full in standalone mode |

## Verification
The bench runs a two-member ring alongside a standalone instance and drives all three from the same strobes.

A wrong arrival-kind bit hands the wrong token to the receiving instance. This shows as a wrong `ownsWr` or `ownsRd` on the receiver two edges after the passing operation, and its strobes are then gated wrongly from the next operation on. A wrong pointer or fill count shows at once on the address outputs. Within one ring lap, it also shows as a hand-off pulse that arrives early, arrives late or never arrives.

The bench computes every token position, address and count arithmetically from the operations accepted so far. It sweeps fill-to-full, drain-to-empty and several hundred mixed cycles.

// File: rtl/chain_pkg.sv
package chain_pkg;

  // Gated strobes handed from the token control to the pointer datapath.
  typedef struct packed {
    logic wrFire;
    logic rdFire;
  } chainStrobe_t;

  // Kind of token the next arrival on the expansion input grants.
  typedef enum logic {
    EXPECT_WR = 1'b0,
    EXPECT_RD = 1'b1
  } arrivalKind_e;

endpackage

// File: rtl/chain_ptr_path.sv
module chain_ptr_path
  import chain_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  chainStrobe_t  strobe,
  output logic [AW-1:0] wrPtr,
  output logic [AW-1:0] rdPtr,
  output logic          wrAtLast,
  output logic          rdAtLast,
  output logic          isFull,
  output logic          isEmpty,
  output logic          overHalf
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_SLOT  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_COUNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_COUNT = CW'(DEPTH / 2);

  logic [CW-1:0] fillCount;

  assign wrAtLast = (wrPtr == LAST_SLOT);
  assign rdAtLast = (rdPtr == LAST_SLOT);
  assign isFull   = (fillCount == FULL_COUNT);
  assign isEmpty  = (fillCount == '0);
  assign overHalf = (fillCount > HALF_COUNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (strobe.wrFire) begin
        wrPtr <= wrAtLast ? '0 : wrPtr + 1'b1;
      end
      if (strobe.rdFire) begin
        rdPtr <= rdAtLast ? '0 : rdPtr + 1'b1;
      end
      if (strobe.wrFire && !strobe.rdFire) begin
        fillCount <= fillCount + 1'b1;
      end else if (strobe.rdFire && !strobe.wrFire) begin
        fillCount <= fillCount - 1'b1;
      end
    end
  end

endmodule

// File: rtl/chain_token_ctrl.sv
module chain_token_ctrl
  import chain_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         expInN,
  input  logic         firstLoadN,
  input  logic         wrReq,
  input  logic         rdReq,
  input  logic         wrAtLast,
  input  logic         rdAtLast,
  input  logic         isFull,
  input  logic         isEmpty,
  output chainStrobe_t strobe,
  output logic         holdWr,
  output logic         holdRd,
  output logic         singleMode,
  output logic         passPulse
);

  logic         live;
  arrivalKind_e nextArrival;
  logic         wrPass;
  logic         rdPass;
  logic         arrival;

  always_comb begin
    strobe.wrFire = live && wrReq && holdWr && !isFull;
    strobe.rdFire = live && rdReq && holdRd && !isEmpty;
  end

  assign wrPass  = strobe.wrFire && wrAtLast;
  assign rdPass  = strobe.rdFire && rdAtLast;
  assign arrival = !singleMode && !expInN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      singleMode  <= ~expInN;
      holdWr      <= ~expInN | ~firstLoadN;
      holdRd      <= ~expInN | ~firstLoadN;
      nextArrival <= EXPECT_WR;
      passPulse   <= 1'b0;
      live        <= 1'b0;
    end else begin
      live      <= 1'b1;
      passPulse <= !singleMode && (wrPass || rdPass);
      if (!singleMode) begin
        if (wrPass) holdWr <= 1'b0;
        if (rdPass) holdRd <= 1'b0;
        if (arrival) begin
          if (nextArrival == EXPECT_WR) begin
            holdWr      <= 1'b1;
            nextArrival <= EXPECT_RD;
          end else begin
            holdRd      <= 1'b1;
            nextArrival <= EXPECT_WR;
          end
        end
      end
    end
  end

endmodule

// File: rtl/depth_chain_link.sv
module depth_chain_link
  import chain_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrReq,
  input  logic          rdReq,
  input  logic          expInN,
  input  logic          firstLoadN,
  output logic          wrGo,
  output logic          rdGo,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          ownsWr,
  output logic          ownsRd,
  output logic          expOutN
);

  chainStrobe_t strobe;
  logic         wrAtLast;
  logic         rdAtLast;
  logic         isFull;
  logic         isEmpty;
  logic         overHalf;
  logic         singleMode;
  logic         passPulse;

  chain_token_ctrl ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .expInN     (expInN),
    .firstLoadN (firstLoadN),
    .wrReq      (wrReq),
    .rdReq      (rdReq),
    .wrAtLast   (wrAtLast),
    .rdAtLast   (rdAtLast),
    .isFull     (isFull),
    .isEmpty    (isEmpty),
    .strobe     (strobe),
    .holdWr     (ownsWr),
    .holdRd     (ownsRd),
    .singleMode (singleMode),
    .passPulse  (passPulse)
  );

  chain_ptr_path #(.DEPTH(DEPTH)) path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrPtr    (wrAddr),
    .rdPtr    (rdAddr),
    .wrAtLast (wrAtLast),
    .rdAtLast (rdAtLast),
    .isFull   (isFull),
    .isEmpty  (isEmpty),
    .overHalf (overHalf)
  );

  assign wrGo    = strobe.wrFire;
  assign rdGo    = strobe.rdFire;
  assign expOutN = singleMode ? ~overHalf : ~passPulse;

endmodule

// File: rtl/depth_chain_link_chk.sv
module depth_chain_link_chk #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrReq,
  input logic          rdReq,
  input logic          wrGo,
  input logic          rdGo,
  input logic [AW-1:0] wrAddr,
  input logic [AW-1:0] rdAddr,
  input logic          ownsWr,
  input logic          ownsRd,
  input logic          expOutN,
  input logic          singleMode
);

  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  // R4
  wr_token_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrGo |-> (wrReq && ownsWr));

  // R4
  rd_token_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdGo |-> (rdReq && ownsRd));

  // R4
  wr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrGo |=> (wrAddr == (($past(wrAddr) == LAST_SLOT) ? '0 : $past(wrAddr) + 1'b1)));

  // R4
  rd_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdGo |=> (rdAddr == (($past(rdAddr) == LAST_SLOT) ? '0 : $past(rdAddr) + 1'b1)));

  // R10
  wr_idle_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrGo |=> $stable(wrAddr));

  // R10
  rd_idle_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdGo |=> $stable(rdAddr));

  // R5
  last_write_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!singleMode && wrGo && wrAddr == LAST_SLOT) |=> (!expOutN && !ownsWr));

  // R6
  last_read_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!singleMode && rdGo && rdAddr == LAST_SLOT) |=> (!expOutN && !ownsRd));

  // R9
  quiet_chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!singleMode && !$past(wrGo && wrAddr == LAST_SLOT)
                 && !$past(rdGo && rdAddr == LAST_SLOT)) |-> expOutN);

  // R3
  standalone_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    singleMode |-> (ownsWr && ownsRd));

endmodule

bind depth_chain_link depth_chain_link_chk #(.DEPTH(DEPTH)) chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrReq      (wrReq),
  .rdReq      (rdReq),
  .wrGo       (wrGo),
  .rdGo       (rdGo),
  .wrAddr     (wrAddr),
  .rdAddr     (rdAddr),
  .ownsWr     (ownsWr),
  .ownsRd     (ownsRd),
  .expOutN    (expOutN),
  .singleMode (singleMode)
);

// File: tb/depth_chain_link_test.sv
module depth_chain_link_test;

  localparam int DEPTH = 4;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrReq = 1'b0;
  logic rdReq = 1'b0;
  logic soloExp = 1'b0;

  always #4 clk = ~clk;

  logic          aWrGo, aRdGo, aOwnsWr, aOwnsRd, aExpN;
  logic          bWrGo, bRdGo, bOwnsWr, bOwnsRd, bExpN;
  logic          sWrGo, sRdGo, sOwnsWr, sOwnsRd, sExpN;
  logic [AW-1:0] aWa, aRa, bWa, bRa, sWa, sRa;

  depth_chain_link #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .rdReq(rdReq),
    .expInN(bExpN), .firstLoadN(1'b0),
    .wrGo(aWrGo), .rdGo(aRdGo), .wrAddr(aWa), .rdAddr(aRa),
    .ownsWr(aOwnsWr), .ownsRd(aOwnsRd), .expOutN(aExpN));

  depth_chain_link #(.DEPTH(DEPTH)) peer (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .rdReq(rdReq),
    .expInN(aExpN), .firstLoadN(1'b1),
    .wrGo(bWrGo), .rdGo(bRdGo), .wrAddr(bWa), .rdAddr(bRa),
    .ownsWr(bOwnsWr), .ownsRd(bOwnsRd), .expOutN(bExpN));

  depth_chain_link #(.DEPTH(DEPTH)) solo (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .rdReq(rdReq),
    .expInN(soloExp), .firstLoadN(1'b1),
    .wrGo(sWrGo), .rdGo(sRdGo), .wrAddr(sWa), .rdAddr(sRa),
    .ownsWr(sOwnsWr), .ownsRd(sOwnsRd), .expOutN(sExpN));

  int total = 0;
  int fails = 0;

  // model: index 0 = uut, 1 = peer, 2 = solo
  int mCnt[3];
  int mWa[3];
  int mRa[3];
  bit mHw[2];
  bit mHr[2];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic doOp(input bit w, input bit r);
    bit ew[3];
    bit er[3];
    bit pw[2];
    bit pr[2];
    wrReq   = w;
    rdReq   = r;
    soloExp = ~soloExp;
    #1;
    for (int d = 0; d < 3; d++) begin
      ew[d] = w && (d == 2 || mHw[d % 2]) && mCnt[d] < DEPTH;
      er[d] = r && (d == 2 || mHr[d % 2]) && mCnt[d] > 0;
    end
    chk("R4 uut wrGo", aWrGo, ew[0]);
    chk("R4 uut rdGo", aRdGo, er[0]);
    chk("R4 peer wrGo", bWrGo, ew[1]);
    chk("R4 peer rdGo", bRdGo, er[1]);
    chk("R3 solo wrGo", sWrGo, ew[2]);
    chk("R3 solo rdGo", sRdGo, er[2]);
    for (int d = 0; d < 2; d++) begin
      pw[d] = ew[d] && mWa[d] == DEPTH - 1;
      pr[d] = er[d] && mRa[d] == DEPTH - 1;
    end
    for (int d = 0; d < 3; d++) begin
      mCnt[d] += int'(ew[d]) - int'(er[d]);
      if (ew[d]) mWa[d] = (mWa[d] + 1) % DEPTH;
      if (er[d]) mRa[d] = (mRa[d] + 1) % DEPTH;
    end
    @(negedge clk);
    wrReq = 1'b0;
    rdReq = 1'b0;
    chk("R5/R6/R9 uut expOutN", aExpN, !(pw[0] || pr[0]));
    chk("R5/R6/R9 peer expOutN", bExpN, !(pw[1] || pr[1]));
    chk("R10 uut wrAddr", aWa, mWa[0]);
    chk("R10 uut rdAddr", aRa, mRa[0]);
    chk("R10 peer wrAddr", bWa, mWa[1]);
    chk("R10 peer rdAddr", bRa, mRa[1]);
    chk("R4 solo wrAddr", sWa, mWa[2]);
    chk("R8 solo expOutN", sExpN, !(mCnt[2] > DEPTH / 2));
    chk("R5 uut ownsWr", aOwnsWr, mHw[0] && !pw[0]);
    chk("R6 uut ownsRd", aOwnsRd, mHr[0] && !pr[0]);
    chk("R5 peer ownsWr", bOwnsWr, mHw[1] && !pw[1]);
    chk("R6 peer ownsRd", bOwnsRd, mHr[1] && !pr[1]);
    for (int d = 0; d < 2; d++) begin
      if (pw[d]) begin mHw[d] = 1'b0; mHw[1 - d] = 1'b1; end
      if (pr[d]) begin mHr[d] = 1'b0; mHr[1 - d] = 1'b1; end
    end
    @(negedge clk);
    chk("R7 uut ownsWr", aOwnsWr, mHw[0]);
    chk("R7 uut ownsRd", aOwnsRd, mHr[0]);
    chk("R7 peer ownsWr", bOwnsWr, mHw[1]);
    chk("R7 peer ownsRd", bOwnsRd, mHr[1]);
    chk("R9 uut expOutN idle", aExpN, 1);
    chk("R9 peer expOutN idle", bExpN, 1);
    chk("R3 solo ownsWr", sOwnsWr, 1);
    chk("R3 solo ownsRd", sOwnsRd, 1);
  endtask

  initial begin
    #(8 * 100000);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int d = 0; d < 3; d++) begin
      mCnt[d] = 0; mWa[d] = 0; mRa[d] = 0;
    end
    mHw[0] = 1'b1; mHr[0] = 1'b1;
    mHw[1] = 1'b0; mHr[1] = 1'b0;
    repeat (4) @(negedge clk);
    rstN    = 1'b1;
    soloExp = 1'b1;
    @(negedge clk);
    chk("R2 uut ownsWr", aOwnsWr, 1);
    chk("R2 uut ownsRd", aOwnsRd, 1);
    chk("R2 peer ownsWr", bOwnsWr, 0);
    chk("R2 peer ownsRd", bOwnsRd, 0);
    chk("R2 uut wrAddr", aWa, 0);
    chk("R2 uut rdAddr", aRa, 0);
    chk("R2 peer wrAddr", bWa, 0);
    chk("R1 solo ownsWr", sOwnsWr, 1);
    chk("R1 solo ownsRd", sOwnsRd, 1);
    chk("R1 uut expOutN", aExpN, 1);
    chk("R1 solo expOutN", sExpN, 1);

    // fill the whole ring and try beyond full
    for (int i = 0; i < 2 * DEPTH + 2; i++) doOp(1'b1, 1'b0);
    // drain it and try beyond empty
    for (int i = 0; i < 2 * DEPTH + 2; i++) doOp(1'b0, 1'b1);
    // mixed patterns, including simultaneous strobes
    for (int i = 0; i < 300; i++) doOp((i % 3) != 2, (i % 5) >= 2 || (i % 7) == 0);
    for (int i = 0; i < 60; i++) doOp(1'b1, 1'b1);
    for (int i = 0; i < 40; i++) doOp((i % 2) == 0, (i % 4) != 0);

    finishRun();
  end

endmodule